// File: doc/BRIEF.md
# Controller Port Strobe and Read-Enable Register

This block sits on a processor bus and provides the control lines for two game-controller ports. When the processor writes to the first port address, the block stores the low bits of the write data. It drives these stored bits out on output pins until the next such write. Bit 0 of those pins is the strobe that both controllers share.

When the processor reads from either port address, the block pulls that port's active-low read enable low. It does this only during the second half of the bus cycle, and at the same time it raises a data-valid flag for the read-data multiplexer.

A test input changes how the address window is decoded. While the test input is high, reads of the two port addresses become open bus: no enable is asserted and the valid flag stays low. In the same mode, a small range of addresses just above the ports drives a diagnostic select output. While the test input is low, that range is ignored.

The bus follows a two-phase cycle. The address and the direction are held for the whole cycle. `phi2` is high during the second half, when data moves. The design runs on a fast system clock, so every phase lasts one or more clock cycles.

Top module: `ctrl_port_reg`

## Requirements
- R1: A write (`rw` = 0) to address 0x4016 while `phi2` is high stores `wdata[2:0]`. `out_pins[2:0]` takes that value on the first clock edge at which `phi2` is low. If `phi2` stays high for several edges, the last value sampled is stored. Bit 0 of `out_pins` is the controller strobe.
- R2: `out_pins` keeps its value at all other times. Reads, writes to any other address (such as 0x4017), and idle cycles leave it unchanged.
- R3: `oe_n[0]` is low exactly while `phi2` is high, `rw` is 1, `addr` is 0x4016 and `test_en` is 0. Otherwise it is high.
- R4: `oe_n[1]` behaves the same way for address 0x4017.
- R5: `rd_valid` is high exactly while one of the `oe_n` bits is low.
- R6: While `test_en` is 1, reads of 0x4016 and 0x4017 leave both `oe_n` bits high and `rd_valid` low.
- R7: While `test_en` is 1, `diag_sel` is high exactly while `phi2` is high and `addr` lies in 0x4018 to 0x401A inclusive. This holds for reads and for writes.
- R8: While `test_en` is 0, `diag_sel` stays low. Writes to 0x4018 to 0x401A do not change `out_pins`.
- R9: While `rst_n` is low, `out_pins` is 0, `oe_n` is 2'b11, and `rd_valid` and `diag_sel` are 0.
- R10: Writes to 0x4016 update `out_pins` in the same way whether `test_en` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every bus phase spans one or more cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address, held for the whole bus cycle |
| wdata | input | 3 | Low write-data bits that the output latch stores |
| rw | input | 1 | Direction: 1 read, 0 write; held for the whole bus cycle |
| phi2 | input | 1 | High during the data half of each bus cycle |
| test_en | input | 1 | Test mode: ports read as open bus, diagnostic range enabled |
| out_pins | output | 3 | Latched output lines; bit 0 is the controller strobe |
| oe_n | output | 2 | Active-low read enables for controller 0 and 1 |
| rd_valid | output | 1 | High while a controller read drives the data mux |
| diag_sel | output | 1 | Diagnostic window selected |

## Verification
The assertions assume that `addr` and `rw` stay stable while `phi2` is high. They also assume that each `phi2` high phase is preceded by at least one cycle with `phi2` low, so that a stored write is committed before the next data phase starts. The stimulus drives every bus access as two clocks of `phi2` low followed by two clocks of `phi2` high, with address, direction and data changing only at the start of the low phase. The test input also changes only between bus cycles, so no phase ever sees a mode change.

// File: rtl/ctrlio_pkg.sv
package ctrlio_pkg;
  localparam int ADDR_W   = 16;
  localparam int NUM_OUT  = 3;
  localparam int NUM_PORT = 2;
  localparam int DIAG_CNT = 3;
  localparam logic [ADDR_W-1:0] PORT_BASE = 16'h4016;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PORT = 2'd1,
    ACC_DIAG = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/ctrlio_decode.sv
module ctrlio_decode
  import ctrlio_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NP = NUM_PORT,
  parameter int ND = DIAG_CNT,
  parameter logic [AW-1:0] BASE = PORT_BASE
) (
  input  logic [AW-1:0] addr,
  output logic [NP-1:0] port_hit,
  output acc_kind_e     kind
);
  localparam logic [AW-1:0] DIAG_LO = BASE + AW'(NP);
  localparam logic [AW-1:0] DIAG_HI = BASE + AW'(NP + ND - 1);

  logic diag_hit;

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign port_hit[i] = (addr == BASE + AW'(i));
  end

  assign diag_hit = (addr >= DIAG_LO) && (addr <= DIAG_HI);

  always_comb begin
    if (|port_hit)     kind = ACC_PORT;
    else if (diag_hit) kind = ACC_DIAG;
    else               kind = ACC_NONE;
  end
endmodule

// File: rtl/ctrlio_out_latch.sv
module ctrlio_out_latch #(
  parameter int NO = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi2,
  input  logic          wr_hit,
  input  logic [NO-1:0] wdata,
  output logic [NO-1:0] out_q
);
  logic [NO-1:0] hold_q;
  logic          pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else if (phi2) begin
      pend_q <= wr_hit;
      if (wr_hit) hold_q <= wdata;
    end else if (pend_q) begin
      out_q  <= hold_q;
      pend_q <= 1'b0;
    end
  end

  a_r2_hold_without_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(out_q));
  a_r1_commit_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !phi2) |=> (out_q == $past(hold_q)));
endmodule

// File: rtl/ctrlio_rd_enable.sv
module ctrlio_rd_enable #(
  parameter int NP = 2
) (
  input  logic          rst_n,
  input  logic          phi2,
  input  logic          rd,
  input  logic          test_en,
  input  logic [NP-1:0] port_hit,
  output logic [NP-1:0] oe_n,
  output logic          rd_valid
);
  logic qual;

  assign qual = rst_n && phi2 && rd && !test_en;

  for (genvar i = 0; i < NP; i++) begin : g_oe
    assign oe_n[i] = !(qual && port_hit[i]);
  end

  assign rd_valid = qual && (|port_hit);
endmodule

// File: rtl/ctrl_port_reg.sv
module ctrl_port_reg
  import ctrlio_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NO = NUM_OUT,
  parameter int NP = NUM_PORT,
  parameter int ND = DIAG_CNT,
  parameter logic [AW-1:0] BASE = PORT_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [NO-1:0] wdata,
  input  logic          rw,
  input  logic          phi2,
  input  logic          test_en,
  output logic [NO-1:0] out_pins,
  output logic [NP-1:0] oe_n,
  output logic          rd_valid,
  output logic          diag_sel
);
  logic [NP-1:0] port_hit;
  acc_kind_e     kind;
  logic          wr_hit;

  ctrlio_decode #(.AW(AW), .NP(NP), .ND(ND), .BASE(BASE)) i_decode (
    .addr     (addr),
    .port_hit (port_hit),
    .kind     (kind)
  );

  assign wr_hit = !rw && port_hit[0];

  ctrlio_out_latch #(.NO(NO)) i_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .phi2   (phi2),
    .wr_hit (wr_hit),
    .wdata  (wdata),
    .out_q  (out_pins)
  );

  ctrlio_rd_enable #(.NP(NP)) i_rden (
    .rst_n    (rst_n),
    .phi2     (phi2),
    .rd       (rw),
    .test_en  (test_en),
    .port_hit (port_hit),
    .oe_n     (oe_n),
    .rd_valid (rd_valid)
  );

  assign diag_sel = rst_n && test_en && phi2 && (kind == ACC_DIAG);

  a_r6_test_ports_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> (oe_n == '1 && !rd_valid));
  a_r3_enable_in_read_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n != '1) |-> (phi2 && rw));
  a_r8_diag_needs_test: assert property (@(posedge clk) disable iff (!rst_n)
    diag_sel |-> (test_en && phi2));
  a_r5_valid_matches_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($countones(~oe_n) == 1));

  always_comb begin
    if (rst_n === 1'b0) begin
      a_r9_reset_quiet: assert (oe_n == '1 && !rd_valid && !diag_sel);
    end
  end
endmodule

// File: tb/test_ctrl_port_reg.sv
module test_ctrl_port_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [2:0]  wdata = 3'b000;
  logic        rw = 1'b1;
  logic        phi2 = 1'b0;
  logic        test_en = 1'b0;
  logic [2:0]  out_pins;
  logic [1:0]  oe_n;
  logic        rd_valid;
  logic        diag_sel;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string out_tag = "R9";

  logic [2:0] m_out = 3'b000;
  logic [2:0] m_data = 3'b000;
  logic       m_armed = 1'b0;

  always #2ns clk = ~clk;

  ctrl_port_reg i_ctrl_port_reg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rw(rw),
    .phi2(phi2), .test_en(test_en), .out_pins(out_pins), .oe_n(oe_n),
    .rd_valid(rd_valid), .diag_sel(diag_sel)
  );

  // Reference model: a write seen in the data phase becomes visible once the phase ends.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out <= 3'b000; m_armed <= 1'b0; m_data <= 3'b000;
    end else if (phi2) begin
      m_armed <= (!rw && addr == 16'h4016);
      if (!rw && addr == 16'h4016) m_data <= wdata;
    end else if (m_armed) begin
      m_out <= m_data; m_armed <= 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, 1 ns after the rising edge.
  always @(posedge clk) begin
    #1ns;
    if (!done) begin
      logic       e_oe0, e_oe1, e_diag;
      e_oe0  = rst_n && phi2 && rw && !test_en && addr == 16'h4016;
      e_oe1  = rst_n && phi2 && rw && !test_en && addr == 16'h4017;
      e_diag = rst_n && test_en && phi2 && addr >= 16'h4018 && addr <= 16'h401A;
      check(out_tag, out_pins, m_out);
      check(test_en ? "R6 oe_n" : "R3/R4 oe_n", oe_n, {!e_oe1, !e_oe0});
      check(test_en ? "R6 rd_valid" : "R5 rd_valid", rd_valid, e_oe0 || e_oe1);
      check(test_en ? "R7 diag_sel" : "R8 diag_sel", diag_sel, e_diag);
    end
  end

  task automatic bus(input logic [15:0] a, input logic r, input logic [2:0] d, input logic t);
    @(negedge clk);
    addr = a; rw = r; wdata = d; test_en = t; phi2 = 1'b0;
    @(negedge clk);
    @(negedge clk); phi2 = 1'b1;
    @(negedge clk);
    @(negedge clk); phi2 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200us;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset out", out_pins, 0);
    check("R9 reset oe", oe_n, 3);
    rst_n = 1'b1;
    out_tag = "R1";
    bus(16'h4016, 1'b0, 3'b101, 1'b0);
    bus(16'h4016, 1'b1, 3'b000, 1'b0);
    @(negedge clk); check("R1 strobe bit", out_pins[0], 1);
    out_tag = "R2";
    bus(16'h4017, 1'b1, 3'b000, 1'b0);
    bus(16'h4017, 1'b0, 3'b010, 1'b0);
    bus(16'h1234, 1'b0, 3'b010, 1'b0);
    @(negedge clk); check("R2 held", out_pins, 3'b101);
    out_tag = "R1";
    bus(16'h4016, 1'b0, 3'b110, 1'b0);
    bus(16'h4015, 1'b1, 3'b000, 1'b0);
    out_tag = "R6";
    bus(16'h4016, 1'b1, 3'b000, 1'b1);
    bus(16'h4017, 1'b1, 3'b000, 1'b1);
    out_tag = "R7";
    bus(16'h4018, 1'b0, 3'b001, 1'b1);
    bus(16'h401A, 1'b1, 3'b000, 1'b1);
    bus(16'h401B, 1'b1, 3'b000, 1'b1);
    out_tag = "R8";
    bus(16'h4018, 1'b0, 3'b001, 1'b0);
    bus(16'h4019, 1'b1, 3'b000, 1'b0);
    @(negedge clk); check("R8 out unchanged", out_pins, 3'b110);
    out_tag = "R10";
    bus(16'h4016, 1'b0, 3'b011, 1'b1);
    @(negedge clk); check("R10 test-mode write", out_pins, 3'b011);
    out_tag = "R9";
    @(negedge clk); addr = 16'h4016; rw = 1'b1; test_en = 1'b0; phi2 = 1'b1; rst_n = 1'b0;
    #1ns;
    check("R9 reset mid-read oe", oe_n, 3);
    check("R9 reset mid-read out", out_pins, 0);
    check("R9 reset valid", rd_valid, 0);
    repeat (2) @(negedge clk);
    phi2 = 1'b0; rst_n = 1'b1;
    out_tag = "R1";
    bus(16'h4016, 1'b0, 3'b111, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 final value", out_pins, 3'b111);
    finish_run();
  end
endmodule